// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital control core of a multichannel successive-approximation converter. A host talks to it over a four-wire serial link (active-low select, bit clock, data in, data out) in 16-bit frames. Each frame carries a command word in and an output word out. A command with its top bit clear writes the mode-control register. That register holds a scan code, a channel number N, a repeat count, a power-mode field, a channel-tag enable and a one-shot software start bit.

Four scan codes exist. The null code leaves the scan mode and channel number alone while the low configuration fields are still written. Manual mode converts the channel named in each frame and returns that result in the next frame. Repeat mode converts channel N a programmed number of times. Ascending scan converts channels 0 to N once each. Both internal modes are started by a rising edge on a convert-start input, or by the software start bit at the end of the frame that writes it. Their tagged results go into a 16-entry FIFO, which is popped one word per frame. The converter itself sits behind a request/done port with exactly one conversion in flight at a time.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the FIFO count is 0, the power-mode output is 00, no conversion is requested, and the first frame returns 0x0000.
- R2: A frame is ignored as a command when bit 15 is 1 or when it does not hold exactly 16 bit-clock rising edges. Such a frame starts no conversion and changes no mode.
- R3: A command with scan code bits [14:11] outside 1..3 (code 0, or 4 to 15) keeps the scan mode and the channel number. It still writes the repeat count [6:5], the power mode [4:3] and the software start [1].
- R4: Scan code 1 (manual) converts the channel in bits [10:7] after the frame ends, and that word is shifted out MSB first in the next frame. A frame in manual mode that names no channel makes the following frame return 0x0000.
- R5: Manual output is {channel, result} when the tag bit [2] was 1 in the naming command, and {4'h0, result} otherwise. FIFO words are always {channel[3:0], result[11:0]}.
- R6: Scan code 2 (repeat) converts channel N (bits [10:7]) 4×(count+1) times, with count from bits [6:5], giving 4, 8, 12 or 16 FIFO words.
- R7: Scan code 3 (ascending) converts channels 0, 1, …, N in order, giving N+1 FIFO words.
- R8: In repeat and ascending modes, a rising edge on the convert-start input, or a software start bit of 1 at the end of its frame, starts a scan. The software start bit clears by itself. In manual mode neither one starts a conversion.
- R9: The conversion request is a one-cycle strobe. No new request is issued while a conversion is outstanding.
- R10: Each frame pops one FIFO word at its start, oldest first, and reads 0x0000 when the FIFO is empty. The count output tracks the contents. A mode command or a scan start flushes the FIFO and discards the result of any interrupted conversion.
- R11: The power-mode field is stored from bits [4:3] and driven on the power-mode output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are oversampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial bit clock |
| mosi | input | 1 | Serial command data, MSB first |
| miso | output | 1 | Serial output word, MSB first |
| cnvst | input | 1 | Convert-start for internal modes, rising edge |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 4 | Channel to convert, valid with conv_req |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 12 | Converter result |
| fifo_count | output | 5 | Words held in the result FIFO |
| pwr_mode | output | 2 | Stored power-mode field |

## Verification
On every cycle the embedded properties check that the FIFO never goes past its depth, and that no request is issued while a conversion is in flight. They also check that the software start bit lives only one cycle, that non-mode commands leave the mode and channel number intact, and that repeat and ascending scans only request legal channels. The ordering and values of results, the one-frame delay in manual mode, the tag formats, the repeat totals and flush-on-restart show only through full frame scenarios. In these the bench sweeps every channel and repeat count, and compares each shifted-out word against results it computes itself.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int DATA_W     = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cs_n,
  input  logic                               sclk,
  input  logic                               mosi,
  output logic                               miso,
  input  logic                               cnvst,
  output logic                               conv_req,
  output logic [3:0]                         conv_ch,
  input  logic                               conv_done,
  input  logic [DATA_W-1:0]                  conv_data,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    fifo_count,
  output logic [1:0]                         pwr_mode
);
  localparam int CH_W   = 4;
  localparam int WORD_W = CH_W + DATA_W;
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int CNT_W  = $clog2(FIFO_DEPTH+1);
  localparam int LEFT_W = CH_W + 1;
  localparam logic [3:0] M_NULL = 4'd0, M_MAN = 4'd1, M_REP = 4'd2, M_SCAN = 4'd3;

  logic cs_s, cs_p, sck_s, sck_p, mosi_s, cnv_s, cnv_p;
  logic [4:0] bcnt;
  logic [14:0] in_sr;
  logic [15:1] cmd;
  logic [WORD_W-1:0] out_sr, out_word, man_word;
  logic [3:0] mode, chsel, man_ch, cur_ch;
  logic [1:0] rep_sel, pm;
  logic chan_id, swcnv;
  logic run, busy, drop, man_pend, kind_man;
  logic [LEFT_W-1:0] left;
  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fcnt;

  wire fs       = cs_p & ~cs_s;
  wire fe       = ~cs_p & cs_s;
  wire sck_rise = sck_s & ~sck_p & ~cs_s;
  wire cnv_rise = cnv_s & ~cnv_p;
  assign cmd = in_sr;
  wire [3:0] scan_f = cmd[14:11];
  wire cmd_ok   = fe && bcnt == 5'd16 && !cmd[15];
  wire is_mode  = cmd_ok && (scan_f == M_MAN || scan_f == M_REP || scan_f == M_SCAN);
  wire internal = mode == M_REP || mode == M_SCAN;
  wire start    = internal && (cnv_rise || swcnv) && !is_mode;
  wire restart  = is_mode || start;
  wire keep     = conv_done && busy && !drop && !restart;
  wire push     = keep && !kind_man;
  wire pop      = fs && mode != M_MAN && fcnt != '0 && !restart;
  wire issue    = !busy && (run || man_pend) && !restart;
  wire [LEFT_W-1:0] rep_total  = LEFT_W'(({3'b000, rep_sel} + 5'd1) << 2);
  wire [LEFT_W-1:0] scan_total = LEFT_W'({1'b0, chsel} + 5'd1);

  assign out_word   = (mode == M_MAN) ? man_word : (fcnt != '0 ? mem[rd_ptr] : '0);
  assign miso       = out_sr[WORD_W-1];
  assign fifo_count = fcnt;
  assign pwr_mode   = pm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 1'b1; cs_p <= 1'b1; sck_s <= 1'b0; sck_p <= 1'b0;
      mosi_s <= 1'b0; cnv_s <= 1'b0; cnv_p <= 1'b0;
      bcnt <= '0; in_sr <= '0; out_sr <= '0;
    end else begin
      cs_s <= cs_n; cs_p <= cs_s; sck_s <= sclk; sck_p <= sck_s;
      mosi_s <= mosi; cnv_s <= cnvst; cnv_p <= cnv_s;
      if (fs) begin
        bcnt   <= '0;
        out_sr <= out_word;
      end else if (sck_rise) begin
        if (bcnt != '1) bcnt <= bcnt + 5'd1;
        if (bcnt < 5'd15) in_sr <= {in_sr[13:0], mosi_s};
        out_sr <= {out_sr[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_NULL; chsel <= '0; chan_id <= 1'b0;
      rep_sel <= '0; pm <= '0; swcnv <= 1'b0;
    end else if (cmd_ok) begin
      rep_sel <= cmd[6:5];
      pm      <= cmd[4:3];
      swcnv   <= cmd[1];
      if (is_mode) begin
        mode    <= scan_f;
        chsel   <= cmd[10:7];
        chan_id <= cmd[2];
      end
    end else begin
      swcnv <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_req <= 1'b0; conv_ch <= '0; run <= 1'b0; busy <= 1'b0; drop <= 1'b0;
      man_pend <= 1'b0; man_ch <= '0; kind_man <= 1'b0; cur_ch <= '0; left <= '0;
    end else begin
      conv_req <= 1'b0;
      if (restart) begin
        run      <= start;
        man_pend <= is_mode && scan_f == M_MAN;
        man_ch   <= cmd[10:7];
        cur_ch   <= (mode == M_REP) ? chsel : '0;
        left     <= (mode == M_REP) ? rep_total : scan_total;
        if (busy) begin
          if (conv_done) begin
            busy <= 1'b0;
            drop <= 1'b0;
          end else begin
            drop <= 1'b1;
          end
        end
      end else if (conv_done && busy) begin
        busy <= 1'b0;
        drop <= 1'b0;
        if (!drop && !kind_man) begin
          left <= left - 1'b1;
          if (left == LEFT_W'(1)) run <= 1'b0;
          if (mode == M_SCAN) cur_ch <= cur_ch + 1'b1;
        end
      end else if (issue) begin
        conv_req <= 1'b1;
        busy     <= 1'b1;
        conv_ch  <= man_pend ? man_ch : cur_ch;
        kind_man <= man_pend;
        man_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      man_word <= '0;
    else if (keep && kind_man)
      man_word <= chan_id ? {conv_ch, conv_data} : {{CH_W{1'b0}}, conv_data};
    else if (fe && mode == M_MAN)
      man_word <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; fcnt <= '0;
    end else if (restart) begin
      wr_ptr <= '0; rd_ptr <= '0; fcnt <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(FIFO_DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(FIFO_DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      fcnt <= fcnt + 1'b1;
      else if (pop && !push) fcnt <= fcnt - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {conv_ch, conv_data};

  a_r10_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CNT_W'(FIFO_DEPTH));
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_req);
  a_r3_null_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && !is_mode) |=> (mode == $past(mode) && chsel == $past(chsel)));
  a_r8_swcnv_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    swcnv |=> !swcnv);
  a_r6_repeat_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !kind_man && mode == M_REP) |-> conv_ch == chsel);
  a_r7_scan_channel_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !kind_man && mode == M_SCAN) |-> conv_ch <= chsel);
endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, cnvst = 1'b0;
  logic miso, conv_req, conv_done = 1'b0;
  logic [3:0] conv_ch;
  logic [11:0] conv_data = '0;
  logic [4:0] fifo_count;
  logic [1:0] pwr_mode;
  int vectors = 0, errors = 0, mseq = 0, mlat = 0, exp_seq = 0;
  logic mbusy = 1'b0;
  logic [3:0] mch = '0;
  logic [15:0] rd, exp_man;

  adc_scan_seq i_adc_scan_seq (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cnvst(cnvst), .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .fifo_count(fifo_count), .pwr_mode(pwr_mode));

  always #4 clk = ~clk;

  function automatic logic [11:0] fres(input logic [3:0] ch, input int s);
    return 12'((int'(ch) * 257 + s * 37 + 5) & 32'hfff);
  endfunction

  function automatic logic [15:0] mk(input logic [3:0] scan, input logic [3:0] ch,
      input logic [1:0] rep, input logic [1:0] pm, input logic cid, input logic sw);
    return {1'b0, scan, ch, rep, pm, cid, sw, 1'b0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic frame(input logic [15:0] cmd, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      r = {r[14:0], miso};
      mosi = cmd[15-i];
      tick(3); sclk = 1'b1; tick(4); sclk = 1'b0; tick(1);
    end
    tick(3); cs_n = 1'b1; mosi = 1'b0;
    tick(24);
  endtask

  task automatic pulse_cnvst();
    @(negedge clk) cnvst = 1'b1;
    tick(2); cnvst = 1'b0;
  endtask

  task automatic drain_repeat(input logic [3:0] ch, input int n);
    logic [15:0] r;
    for (int i = 0; i < n; i++) begin
      frame(16'h0000, 16, r);
      check("R6 repeat word", r, {ch, fres(ch, exp_seq)});
      exp_seq++;
    end
  endtask

  task automatic drain_scan(input int n);
    logic [15:0] r;
    for (int i = 0; i < n; i++) begin
      frame(16'h0000, 16, r);
      check("R7 R5 scan word", r, {4'(i), fres(4'(i), exp_seq)});
      exp_seq++;
    end
  endtask

  // converter model: one result per request after a varying latency
  initial begin
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (mbusy) begin
        if (mlat == 0) begin
          conv_done = 1'b1; conv_data = fres(mch, mseq); mseq++; mbusy = 1'b0;
        end else mlat--;
      end
      if (conv_req === 1'b1) begin
        check("R9 single outstanding request", mbusy, 1'b0);
        mbusy = 1'b1; mch = conv_ch; mlat = mseq % 4;
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    vectors++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(3);
    check("R1 fifo count", fifo_count, 0);
    check("R1 power mode", pwr_mode, 0);
    check("R1 no request", conv_req, 0);
    frame(16'h0000, 16, rd);
    check("R1 first word", rd, 16'h0000);

    // manual mode, both tag settings, every channel
    exp_man = '0;
    for (int cid = 0; cid < 2; cid++)
      for (int ch = 0; ch < 16; ch++) begin
        frame(mk(4'd1, 4'(ch), 2'd0, 2'd0, 1'(cid), 1'b0), 16, rd);
        check("R4 R5 manual word", rd, exp_man);
        exp_man = {cid != 0 ? 4'(ch) : 4'h0, fres(4'(ch), exp_seq)};
        exp_seq++;
      end
    frame(16'h0000, 16, rd);
    check("R4 manual word before null", rd, exp_man);
    exp_man = '0;
    check("R4 null frame starts nothing", mseq, exp_seq);
    frame(mk(4'd1, 4'd3, 2'd0, 2'd0, 1'b1, 1'b1), 16, rd);
    check("R4 word after null frame", rd, 16'h0000);
    exp_man = {4'd3, fres(4'd3, exp_seq)}; exp_seq++;
    tick(10);
    check("R8 software start ignored in manual", mseq, exp_seq);
    pulse_cnvst(); tick(40);
    check("R8 convert-start ignored in manual", mseq, exp_seq);
    frame(16'h8000 | mk(4'd1, 4'd7, 2'd0, 2'd0, 1'b1, 1'b0), 16, rd);
    check("R4 tagged manual word", rd, exp_man);
    check("R2 bit15 frame converts nothing", mseq, exp_seq);
    exp_man = '0;
    frame(mk(4'd1, 4'd9, 2'd0, 2'd0, 1'b0, 1'b0), 8, rd);
    check("R2 short frame converts nothing", mseq, exp_seq);
    frame(mk(4'd1, 4'd9, 2'd0, 2'd0, 1'b0, 1'b0), 16, rd);
    check("R2 word after ignored frames", rd, 16'h0000);
    exp_man = {4'h0, fres(4'd9, exp_seq)}; exp_seq++;

    // repeat mode sweeps
    for (int k = 0; k < 3; k++) begin
      for (int sel = 0; sel < 4; sel++) begin
        logic [3:0] ch;
        ch = (k == 0) ? 4'd0 : (k == 1) ? 4'd5 : 4'd15;
        frame(mk(4'd2, ch, 2'(sel), 2'd0, 1'b0, 1'b0), 16, rd);
        check("R4 manual word leaving manual", rd, exp_man);
        exp_man = '0;
        check("R10 flushed on mode command", fifo_count, 0);
        pulse_cnvst(); tick(300);
        check("R6 repeat count", fifo_count, 4 * (sel + 1));
        drain_repeat(ch, 4 * (sel + 1));
        check("R10 count after drain", fifo_count, 0);
        frame(16'h0000, 16, rd);
        check("R10 empty reads zero", rd, 16'h0000);
      end
    end
    // null keeps repeat channel, writes repeat count and power mode
    frame(mk(4'd0, 4'd2, 2'd3, 2'd1, 1'b0, 1'b1), 16, rd);
    check("R11 power mode from null", pwr_mode, 2'd1);
    tick(300);
    check("R3 null keeps repeat channel", fifo_count, 16);
    drain_repeat(4'd15, 16);

    // ascending scans for every N
    for (int n = 0; n < 16; n++) begin
      frame(mk(4'd3, 4'(n), 2'd0, 2'd3, 1'b0, 1'b1), 16, rd);
      tick(300);
      check("R7 scan count", fifo_count, n + 1);
      check("R11 power mode from mode command", pwr_mode, 2'd3);
      drain_scan(n + 1);
    end
    frame(16'h0000, 16, rd);
    check("R8 software start cleared", mseq, exp_seq);
    // code 5 acts as null with a start; channel field ignored
    frame(mk(4'd5, 4'd1, 2'd0, 2'd0, 1'b0, 1'b1), 16, rd);
    tick(300);
    check("R3 unused code keeps N", fifo_count, 16);
    drain_scan(16);
    frame(16'h8000 | mk(4'd2, 4'd9, 2'd0, 2'd0, 1'b0, 1'b1), 16, rd);
    tick(100);
    check("R2 ignored frame no start", fifo_count, 0);
    pulse_cnvst(); tick(300);
    check("R8 R2 convert-start scan after ignored frame", fifo_count, 16);
    drain_scan(16);

    // restart mid-scan discards partial results
    frame(mk(4'd3, 4'd15, 2'd0, 2'd0, 1'b0, 1'b1), 16, rd);
    pulse_cnvst(); tick(300);
    check("R10 restart count", fifo_count, 16);
    exp_seq = mseq - 16;
    drain_scan(16);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule